// File: doc/BRIEF.md
# Floating-Point Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline that has one integer execution unit and several floating-point execution units. Each cycle it looks at the instruction waiting in decode and decides whether that instruction may be sent to its execution unit or must be held. Three hazards are checked. An unpipelined unit that is still busy blocks a new operation of its own type. A new floating-point result cannot be granted the single floating-point register-file write port in a cycle that an older operation has already claimed. A new result cannot target a register that an older operation will write even later.

On issue the block records when the new result will be written back. It keeps a shift register of claimed write-port cycles, a countdown for each floating-point register, and a busy countdown for each unpipelined unit. Its outputs are an issue/stall pair and a one-hot start pulse for the selected unit. The execution units and operand forwarding live elsewhere.

Top module: `fp_issue_hazard`

## Requirements
- R1: After reset no unit is busy, no write-port cycle is claimed and no register has a result pending, so the first valid instruction issues.
- R2: Unit codes are fixed: 0 integer (latency 1, pipelined, writes no FP register), 1 FP add (latency 4, pipelined), 2 FP multiply (latency 7, pipelined), 3 FP divide (latency 10, unpipelined). An op issued in cycle t with latency L writes back in cycle t+L.
- R3: id_issue is high exactly when id_valid is high and no hazard holds; id_stall is high exactly when id_valid is high and a hazard holds; unit_start has only the bit of id_unit set during issue and is zero otherwise.
- R4: Pipelined units accept a new operation in every cycle when no other hazard holds.
- R5: After the divide unit starts in cycle t, another divide is stalled in cycles t+1 to t+9 and may issue in cycle t+10.
- R6: An FP op whose writeback cycle equals the writeback cycle of an already issued FP op is stalled.
- R7: An FP op is stalled when an issued op targeting the same FP register writes back later than the new op would.
- R8: Integer-unit ops never stall and neither claim the write port nor record a pending register.
- R9: A stalled instruction changes no state: it claims no writeback cycle, records no pending register and does not occupy a unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_unit | input | 2 | Execution unit code of that instruction |
| id_dest | input | 5 | Destination FP register |
| id_issue | output | 1 | Instruction is sent to its unit this cycle |
| id_stall | output | 1 | Instruction is held in decode this cycle |
| unit_start | output | 4 | One-hot start pulse per execution unit |

## Verification
The write-port check and the same-register check can both bear on one waiting instruction, and the cycle where one stops holding can be the cycle where the other starts. A divide to a register followed by repeated attempts of an add to the same register walks through that hand-off: the add is first blocked by the later pending divide result, then for one cycle by the shared writeback cycle, and only issues after both clear. A cycle-exact bench model that tracks absolute writeback cycles judges every cycle of that sequence and of long random streams where both conditions arise by chance.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;

    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = $clog2(NUM_UNITS);
    localparam int NUM_FREGS = 32;
    localparam int REG_W     = $clog2(NUM_FREGS);
    localparam int MAX_LAT   = 10;
    localparam int LAT_W     = $clog2(MAX_LAT + 1);
    localparam int INT_UNIT  = 0;

    typedef logic [LAT_W-1:0] lat_t;

    typedef struct packed {
        lat_t latency;
        logic pipelined;
        logic fp_write;
    } unit_cfg_t;

    typedef struct packed {
        logic busy;
        logic port;
        logic waw;
    } hazard_t;

    function automatic unit_cfg_t unit_cfg(input int idx);
        unit_cfg_t c;
        case (idx)
            0:       c = '{latency: lat_t'(1),  pipelined: 1'b1, fp_write: 1'b0};
            1:       c = '{latency: lat_t'(4),  pipelined: 1'b1, fp_write: 1'b1};
            2:       c = '{latency: lat_t'(7),  pipelined: 1'b1, fp_write: 1'b1};
            default: c = '{latency: lat_t'(10), pipelined: 1'b0, fp_write: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fp_unit_busy.sv
module fp_unit_busy #(
    parameter int LATENCY = 10,
    parameter int LAT_W   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [LAT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= LAT_W'(LATENCY - 1);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/fp_wb_reserve.sv
module fp_wb_reserve #(
    parameter int MAX_LAT = 10,
    parameter int LAT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] query_lat,
    input  logic             claim,
    output logic             conflict
);
    // slot[k] set: the write port is taken k cycles from now
    logic [MAX_LAT:1] slot;
    logic [MAX_LAT:1] slot_nxt;

    always_comb begin
        conflict = 1'b0;
        for (int k = 1; k <= MAX_LAT; k++) begin
            if (query_lat == LAT_W'(k) && slot[k]) conflict = 1'b1;
        end
    end

    always_comb begin
        slot_nxt = '0;
        for (int k = 1; k < MAX_LAT; k++) begin
            slot_nxt[k] = slot[k+1] | (claim && query_lat == LAT_W'(k + 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot <= '0;
        else     slot <= slot_nxt;
    end
endmodule

// File: rtl/fp_waw_track.sv
module fp_waw_track #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5,
    parameter int LAT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] q_dest,
    input  logic [LAT_W-1:0] q_lat,
    input  logic             claim,
    output logic             waw
);
    // cycles left until the newest pending result of each register lands
    logic [LAT_W-1:0] pend [NUM_REGS];

    assign waw = pend[q_dest] > q_lat;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[r] <= '0;
            end else if (claim && q_dest == REG_W'(r)) begin
                pend[r] <= q_lat - 1'b1;
            end else if (pend[r] != '0) begin
                pend[r] <= pend[r] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fp_issue_hazard.sv
module fp_issue_hazard
    import fp_issue_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 id_valid,
    input  logic [UNIT_W-1:0]    id_unit,
    input  logic [REG_W-1:0]     id_dest,
    output logic                 id_issue,
    output logic                 id_stall,
    output logic [NUM_UNITS-1:0] unit_start
);
    unit_cfg_t            cfg;
    hazard_t              haz;
    logic [NUM_UNITS-1:0] unit_busy;
    logic                 port_conflict;
    logic                 waw_hit;
    logic                 fp_claim;

    always_comb begin
        cfg      = unit_cfg(int'(id_unit));
        haz.busy = unit_busy[id_unit];
        haz.port = cfg.fp_write && port_conflict;
        haz.waw  = cfg.fp_write && waw_hit;
    end

    assign id_stall = id_valid &&  (|haz);
    assign id_issue = id_valid && !(|haz);
    assign fp_claim = id_issue && cfg.fp_write;

    always_comb begin
        unit_start = '0;
        if (id_issue) unit_start[id_unit] = 1'b1;
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam unit_cfg_t UC = unit_cfg(u);
        if (!UC.pipelined && UC.latency > 1) begin : g_blocking
            fp_unit_busy #(
                .LATENCY(int'(UC.latency)),
                .LAT_W  (LAT_W)
            ) u_busy (
                .clk  (clk),
                .rst  (rst),
                .start(unit_start[u]),
                .busy (unit_busy[u])
            );
        end else begin : g_streaming
            assign unit_busy[u] = 1'b0;
        end
    end

    fp_wb_reserve #(
        .MAX_LAT(MAX_LAT),
        .LAT_W  (LAT_W)
    ) u_port (
        .clk      (clk),
        .rst      (rst),
        .query_lat(cfg.latency),
        .claim    (fp_claim),
        .conflict (port_conflict)
    );

    fp_waw_track #(
        .NUM_REGS(NUM_FREGS),
        .REG_W   (REG_W),
        .LAT_W   (LAT_W)
    ) u_waw (
        .clk   (clk),
        .rst   (rst),
        .q_dest(id_dest),
        .q_lat (cfg.latency),
        .claim (fp_claim),
        .waw   (waw_hit)
    );
endmodule

// File: rtl/fp_issue_hazard_chk.sv
module fp_issue_hazard_chk
    import fp_issue_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 id_valid,
    input logic [UNIT_W-1:0]    id_unit,
    input logic                 id_issue,
    input logic                 id_stall,
    input logic [NUM_UNITS-1:0] unit_start
);
    a_r1_first_issues: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && id_valid |-> id_issue);

    a_r3_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(unit_start));

    a_r3_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
        id_stall |-> id_valid && !id_issue);

    a_r3_start_on_issue: assert property (@(posedge clk) disable iff (rst)
        (unit_start != '0) |-> id_issue && unit_start[id_unit]);

    a_r8_int_never_stalls: assert property (@(posedge clk) disable iff (rst)
        id_valid && id_unit == UNIT_W'(INT_UNIT) |-> id_issue);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        localparam unit_cfg_t UC = unit_cfg(u);
        if (!UC.pipelined && UC.latency > 1) begin : g_blk
            a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
                unit_start[u] |=> !unit_start[u]);
        end
    end
endmodule

bind fp_issue_hazard fp_issue_hazard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .id_valid  (id_valid),
    .id_unit   (id_unit),
    .id_issue  (id_issue),
    .id_stall  (id_stall),
    .unit_start(unit_start)
);

// File: tb/tb_fp_issue_hazard.sv
module tb_fp_issue_hazard;
    import fp_issue_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 id_valid = 1'b0;
    logic [UNIT_W-1:0]    id_unit = '0;
    logic [REG_W-1:0]     id_dest = '0;
    logic                 id_issue;
    logic                 id_stall;
    logic [NUM_UNITS-1:0] unit_start;

    fp_issue_hazard dut (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_unit(id_unit),
        .id_dest(id_dest), .id_issue(id_issue), .id_stall(id_stall),
        .unit_start(unit_start)
    );

    always #10 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    longint slot_at [64];
    longint reg_wb  [32];
    longint div_free = 0;

    function automatic int lat_of(int u);
        case (u)
            0: return 1;
            1: return 4;
            2: return 7;
            default: return 10;
        endcase
    endfunction

    function automatic bit model_ok(bit v, int u, int d);
        longint wb;
        if (!v) return 1'b0;
        if (u == 0) return 1'b1;
        wb = cyc + lat_of(u);
        if (u == 3 && cyc < div_free) return 1'b0;
        if (slot_at[int'(wb % 64)] == wb) return 1'b0;
        if (reg_wb[d] > wb) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_commit(int u, int d);
        longint wb;
        if (u == 0) return;
        wb = cyc + lat_of(u);
        slot_at[int'(wb % 64)] = wb;
        reg_wb[d] = wb;
        if (u == 3) div_free = cyc + 10;
    endtask

    task automatic chk(longint got, longint exp, string req, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, got, exp);
        end
    endtask

    task automatic step(bit v, int u, int d, string req, output bit issued);
        bit exp;
        @(negedge clk);
        id_valid = v;
        id_unit  = UNIT_W'(u);
        id_dest  = REG_W'(d);
        #2;
        exp = model_ok(v, u, d);
        chk(id_issue, exp, req, "issue");
        chk(id_stall, v && !exp, req, "stall");
        chk(unit_start, exp ? (longint'(1) << u) : 0, req, "unit_start");
        if (exp) model_commit(u, d);
        issued = id_issue;
        @(posedge clk);
        cyc++;
    endtask

    task automatic drain();
        bit s;
        for (int i = 0; i < 12; i++) step(1'b0, 0, 0, "R3", s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit s;
        for (int i = 0; i < 64; i++) slot_at[i] = -1;
        for (int i = 0; i < 32; i++) reg_wb[i] = -1;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: clean state, first op issues
        step(1'b1, 3, 1, "R1", s);
        chk(s, 1, "R1", "first op");
        drain();
        // R4: back-to-back pipelined ops
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1, 2 + i, "R4", s);
            chk(s, 1, "R4", "add stream");
        end
        drain();
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 2, 10 + i, "R4", s);
            chk(s, 1, "R4", "mul stream");
        end
        drain();
        // R5: divide occupancy
        step(1'b1, 3, 2, "R5", s);
        for (int k = 1; k <= 10; k++) begin
            step(1'b1, 3, 3, "R5", s);
            chk(s, k == 10, "R5", "div retry");
        end
        drain();
        // R6: shared writeback cycle
        step(1'b1, 2, 4, "R6", s);
        step(1'b0, 0, 0, "R6", s);
        step(1'b0, 0, 0, "R6", s);
        step(1'b1, 1, 5, "R6", s);
        chk(s, 0, "R6", "add colliding with mul");
        step(1'b1, 1, 5, "R6", s);
        chk(s, 1, "R6", "add one cycle later");
        drain();
        // R9: a stalled divide claims nothing
        step(1'b1, 3, 6, "R9", s);
        step(1'b1, 3, 7, "R9", s);
        chk(s, 0, "R9", "stalled div");
        step(1'b0, 0, 0, "R9", s);
        step(1'b0, 0, 0, "R9", s);
        step(1'b1, 2, 7, "R9", s);
        chk(s, 1, "R9", "mul into stalled div slot");
        drain();
        // R7: same-register later completion, then port hand-off
        step(1'b1, 3, 9, "R7", s);
        for (int k = 1; k <= 7; k++) begin
            step(1'b1, 1, 9, "R7", s);
            chk(s, k == 7, "R7", "add behind div same dest");
        end
        drain();
        // R8: integer ops while FP state is full
        step(1'b1, 3, 1, "R8", s);
        for (int k = 0; k < 5; k++) begin
            step(1'b1, 0, 1, "R8", s);
            chk(s, 1, "R8", "integer op");
        end
        step(1'b1, 2, 1, "R8", s);
        chk(s, 1, "R8", "mul after ints");
        drain();
        // R2/R3: random stream checked against the model
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) < 7, int'($urandom % 4), int'($urandom % 8), "R2", s);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule